// File: doc/BRIEF.md
# Static-Radix Fractional Arithmetic Unit

This block is a single-issue arithmetic unit for W-bit two's-complement fractions in 1.(W-1) format: one sign bit, W-1 fraction bits. Where the binary point sits is worked out ahead of time by the code that drives the unit. The unit never looks for leading bits at run time. Each operation instead carries a few static flags that select fixed one-bit shifts. These let the program keep values in range and keep precision without a full floating-point aligner or normaliser.

Three kinds of operation exist:
- **Add/subtract.** Runs on a W+1-bit adder. Each operand can optionally be halved on the way in, and the sum can optionally be halved on the way out.
- **Fractional multiply.** Rounds its result and can optionally be doubled before rounding.
- **Arithmetic right shift.** Shifts by 0 to W-1 places.

The operands, the opcode and the flags arrive together with an input valid strobe. The result is registered and appears with an output valid strobe on the next clock.

Top module: `sfp_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, both `out_valid` and `result` are cleared to 0 on that edge, whatever the other inputs are.
- R2: `out_valid` is `in_valid` delayed by one clock. `result` changes only on an edge where `in_valid` was high; otherwise it keeps its value.
- R3: With opcode 2'b00, the result is a + b, computed exactly in W+1 bits. When `half_a` is set, a is replaced by floor(a/2) before the add, and `half_b` does the same for b.
- R4: With opcode 2'b01, the result is a - b, with the same optional input halving as R3.
- R5: For opcodes 2'b00 and 2'b01 with `post_norm` set, the result is floor(sum/2) of the W+1-bit sum. This result always fits in W bits and never saturates.
- R6: For opcodes 2'b00 and 2'b01 with `post_norm` clear, a sum outside the W-bit range is clamped to 0x7FFF..F (too large) or 0x800..0 (too small).
- R7: With opcode 2'b10 and `post_norm` clear, the result is floor((a*b + 2^(W-2)) / 2^(W-1)). This is the fraction product rounded half-up, saturated to the W-bit range.
- R8: With opcode 2'b10 and `post_norm` set, the product is doubled before rounding: floor((a*b + 2^(W-3)) / 2^(W-2)), saturated to the W-bit range.
- R9: With opcode 2'b10 and `post_norm` clear, multiplying the most negative value by itself gives the most positive value, 0x7FFF..F.
- R10: With opcode 2'b11, the result is a shifted right arithmetically by `shamt` places (0 to W-1), with the sign filling from the left. `b`, `half_a`, `half_b` and `post_norm` have no effect on it.
- R11: The multiply ignores `half_a`, `half_b` and `shamt`. Add and subtract ignore `shamt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| op | input | 2 | 00 add, 01 subtract, 10 multiply, 11 right shift |
| a | input | W | First operand (shift source) |
| b | input | W | Second operand |
| half_a | input | 1 | Halve a before add/subtract |
| half_b | input | 1 | Halve b before add/subtract |
| post_norm | input | 1 | Add/sub: halve the sum; multiply: double the product |
| shamt | input | $clog2(W) | Right-shift distance for opcode 11 |
| out_valid | output | 1 | Result valid |
| result | output | W | Registered result |

## Verification
The hardest cases to reach are at the edges of the multiplier's range. These are the rounding carry that just pushes a product into saturation, the doubled product of two large fractions, and the square of the most negative value. Uniform random operands almost never produce them. The stimulus therefore draws each operand half the time from a small set of extreme values: the two limits, plus and minus one LSB, and the half value. It combines these with every flag setting. Alongside that run there are directed cases for the exact rounding boundary, for floor-halving of odd negative values, and for every shift distance applied to a negative source.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_SHR = 2'b11
  } sfp_op_e;
endpackage

// File: rtl/sfp_sat.sv
// Clamp a wide signed value into an OW-bit signed range.
module sfp_sat #(
  parameter int IW = 17,
  parameter int OW = 16
) (
  input  logic [IW-1:0] din,
  output logic [OW-1:0] dout
);
  localparam logic [OW-1:0] POS_MAX = {1'b0, {(OW-1){1'b1}}};
  localparam logic [OW-1:0] NEG_MIN = {1'b1, {(OW-1){1'b0}}};

  logic [IW-OW:0] top_bits;
  logic           fits;

  assign top_bits = din[IW-1:OW-1];
  // The value fits when every bit above the output sign matches it.
  assign fits = (&top_bits) | ~(|top_bits);

  always_comb begin
    if (fits)             dout = din[OW-1:0];
    else if (din[IW-1])   dout = NEG_MIN;
    else                  dout = POS_MAX;
  end
endmodule

// File: rtl/sfp_addsub.sv
// W+1-bit adder/subtractor with optional one-bit right aligners on the inputs
// and an optional one-bit right normaliser on the output.
module sfp_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         half_a,
  input  logic         half_b,
  input  logic         post_norm,
  output logic [W-1:0] y
);
  localparam int XW = W + 1;

  logic signed [XW-1:0] ext_a, ext_b, opa, opb, sum;
  logic [W-1:0]         clamped;

  assign ext_a = {a[W-1], a};
  assign ext_b = {b[W-1], b};
  assign opa   = half_a ? (ext_a >>> 1) : ext_a;
  assign opb   = half_b ? (ext_b >>> 1) : ext_b;
  assign sum   = sub ? (opa - opb) : (opa + opb);

  sfp_sat #(.IW(XW), .OW(W)) u_sat (
    .din  (sum),
    .dout (clamped)
  );

  // Dropping the LSB of the W+1-bit sum is the arithmetic halving.
  assign y = post_norm ? sum[XW-1:1] : clamped;
endmodule

// File: rtl/sfp_fmul.sv
// Fractional 1.(W-1) multiplier, rounding half-up, optional doubling.
module sfp_fmul #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         dbl,
  output logic [W-1:0] y
);
  localparam int PW = 2 * W;
  localparam logic [PW:0] HALF_STD = {{PW{1'b0}}, 1'b1} << (W - 2);
  localparam logic [PW:0] HALF_DBL = {{PW{1'b0}}, 1'b1} << (W - 3);

  logic signed [PW-1:0] prod;
  logic signed [PW:0]   biased, scaled;

  assign prod   = $signed(a) * $signed(b);
  assign biased = $signed({prod[PW-1], prod}) + $signed(dbl ? HALF_DBL : HALF_STD);
  assign scaled = dbl ? (biased >>> (W - 2)) : (biased >>> (W - 1));

  sfp_sat #(.IW(PW + 1), .OW(W)) u_sat (
    .din  (scaled),
    .dout (y)
  );
endmodule

// File: rtl/sfp_shr.sv
// Logarithmic arithmetic right barrel shifter.
module sfp_shr #(
  parameter int W = 16
) (
  input  logic [W-1:0]         din,
  input  logic [$clog2(W)-1:0] shamt,
  output logic [W-1:0]         dout
);
  localparam int SW = $clog2(W);

  logic [W-1:0] stage [0:SW];

  assign stage[0] = din;

  for (genvar i = 0; i < SW; i++) begin : g_stage
    localparam int D = 1 << i;
    assign stage[i+1] = shamt[i]
                      ? {{D{stage[i][W-1]}}, stage[i][W-1:D]}
                      : stage[i];
  end

  assign dout = stage[SW];
endmodule

// File: rtl/sfp_unit.sv
module sfp_unit #(
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [1:0]           op,
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  input  logic                 half_a,
  input  logic                 half_b,
  input  logic                 post_norm,
  input  logic [$clog2(W)-1:0] shamt,
  output logic                 out_valid,
  output logic [W-1:0]         result
);
  import sfp_pkg::*;

  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  sfp_op_e      op_e;
  logic [W-1:0] as_y, mul_y, shr_y, next_y;

  assign op_e = sfp_op_e'(op);

  sfp_addsub #(.W(W)) u_addsub (
    .a         (a),
    .b         (b),
    .sub       (op_e == OP_SUB),
    .half_a    (half_a),
    .half_b    (half_b),
    .post_norm (post_norm),
    .y         (as_y)
  );

  sfp_fmul #(.W(W)) u_fmul (
    .a   (a),
    .b   (b),
    .dbl (post_norm),
    .y   (mul_y)
  );

  sfp_shr #(.W(W)) u_shr (
    .din   (a),
    .shamt (shamt),
    .dout  (shr_y)
  );

  always_comb begin
    unique case (op_e)
      OP_ADD, OP_SUB: next_y = as_y;
      OP_MUL:         next_y = mul_y;
      default:        next_y = shr_y;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_y;
    end
  end

  // R1: reset clears the output state
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));

  // R2: valid latency and hold
  a_r2_valid_lat: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  // R4: x - x with no shifts is zero
  a_r4_self_sub: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b01 && a == b && !half_a && !half_b) |=> result == '0);

  // R6: sum of two non-negatives never wraps to negative
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b00 && !a[W-1] && !b[W-1]) |=> !result[W-1]);

  // R9: most negative squared saturates to the most positive value
  a_r9_neg_square: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b10 && !post_norm && a == NEG_MIN && b == NEG_MIN)
      |=> result == POS_MAX);

  // R7: product with zero is zero
  a_r7_zero_prod: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b10 && b == '0) |=> result == '0);

  // R10: shift keeps the sign and shift by zero passes the value
  a_r10_sign_kept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b11) |=> result[W-1] == $past(a[W-1]));
  a_r10_zero_shift: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b11 && shamt == '0) |=> result == $past(a));
endmodule

// File: tb/sim_sfp_unit.sv
module sim_sfp_unit;
  localparam int W  = 16;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rst_next = 1'b1;
  logic          in_valid = 1'b0;
  logic [1:0]    op = 2'b00;
  logic [W-1:0]  a = '0, b = '0;
  logic          half_a = 1'b0, half_b = 1'b0, post_norm = 1'b0;
  logic [SW-1:0] shamt = '0;
  logic          out_valid;
  logic [W-1:0]  result;

  int            total = 0;
  int            bad = 0;
  int            cyc = 0;
  logic          exp_val = 1'b0;
  logic [W-1:0]  exp_res = '0;
  string         exp_tag = "R1";

  always #10 clk = ~clk;

  sfp_unit #(.W(W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .a(a), .b(b),
    .half_a(half_a), .half_b(half_b), .post_norm(post_norm), .shamt(shamt),
    .out_valid(out_valid), .result(result)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<=150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int clamp(int v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic logic [W-1:0] model(logic [1:0] o, logic [W-1:0] x_in,
      logic [W-1:0] y_in, logic ha, logic hb, logic nm, logic [SW-1:0] sh,
      output string tag);
    int x, y, s, r;
    longint p, q;
    x = int'($signed(x_in));
    y = int'($signed(y_in));
    case (o)
      2'b00, 2'b01: begin
        if (ha) x = x >>> 1;
        if (hb) y = y >>> 1;
        s = (o == 2'b01) ? x - y : x + y;
        if (nm) begin
          r = s >>> 1;
          tag = "R5";
        end else begin
          r = clamp(s);
          tag = (r != s) ? "R6" : ((o == 2'b01) ? "R4" : "R3");
        end
      end
      2'b10: begin
        p = longint'(x) * longint'(y);
        if (nm) q = (p + 64'sd8192) >>> 14;
        else    q = (p + 64'sd16384) >>> 15;
        if (q > 32767) q = 32767;
        if (q < -32768) q = -32768;
        r = int'(q);
        if (!nm && x_in == 16'h8000 && y_in == 16'h8000) tag = "R9";
        else tag = nm ? "R8" : "R7";
      end
      default: begin
        r = x >>> sh;
        tag = "R10";
      end
    endcase
    return r[W-1:0];
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic step(logic v = 1'b0, logic [1:0] o = 2'b00,
      logic [W-1:0] xa = '0, logic [W-1:0] xb = '0, logic ha = 1'b0,
      logic hb = 1'b0, logic nm = 1'b0, logic [SW-1:0] sh = '0,
      string ovr = "");
    string t;
    @(negedge clk);
    check("R2", {{(W-1){1'b0}}, out_valid}, {{(W-1){1'b0}}, exp_val});
    check(exp_tag, result, exp_res);
    rst = rst_next;
    in_valid = v; op = o; a = xa; b = xb;
    half_a = ha; half_b = hb; post_norm = nm; shamt = sh;
    if (rst) begin
      exp_val = 1'b0;
      exp_res = '0;
      exp_tag = "R1";
    end else begin
      exp_val = v;
      if (v) begin
        exp_res = model(o, xa, xb, ha, hb, nm, sh, t);
        exp_tag = (ovr != "") ? ovr : t;
      end else begin
        exp_tag = "R2";
      end
    end
  endtask

  function automatic logic [W-1:0] pick();
    logic [W-1:0] corner [0:7];
    corner[0] = 16'h7FFF; corner[1] = 16'h8000; corner[2] = 16'h0001;
    corner[3] = 16'hFFFF; corner[4] = 16'h4000; corner[5] = 16'hC000;
    corner[6] = 16'h8001; corner[7] = 16'h0000;
    if ($urandom_range(1, 0) == 0) return corner[$urandom_range(7, 0)];
    return 16'($urandom);
  endfunction

  initial begin
    // R1: reset holds outputs clear even with a valid operation applied
    step(1'b1, 2'b00, 16'h1234, 16'h1111);
    step(1'b1, 2'b10, 16'h4000, 16'h4000);
    step(1'b1, 2'b11, 16'h8000, 16'h0, 1'b0, 1'b0, 1'b0, 4'd3);
    rst_next = 1'b0;
    // R3 add, R6 saturation, R4 subtract
    step(1'b1, 2'b00, 16'h4000, 16'h2000);
    step(1'b1, 2'b00, 16'h7000, 16'h2000);
    step(1'b1, 2'b01, 16'h8000, 16'h0001);
    step(1'b1, 2'b01, 16'h1234, 16'h0234);
    step(1'b1, 2'b00, 16'h7FFF, 16'h4000, 1'b1);
    step(1'b1, 2'b00, 16'hFFFF, 16'h0000, 1'b1);
    step(1'b1, 2'b01, 16'h0003, 16'hFFFD, 1'b1, 1'b1);
    // R5 output halving
    step(1'b1, 2'b00, 16'h7FFF, 16'h7FFF, 1'b0, 1'b0, 1'b1);
    step(1'b1, 2'b01, 16'h8000, 16'h7FFF, 1'b0, 1'b0, 1'b1);
    // R2 idle cycles keep the result
    step(1'b0, 2'b10, 16'h1111, 16'h2222);
    step(1'b0);
    // R7, R8, R9 multiply
    step(1'b1, 2'b10, 16'h4000, 16'h4000);
    step(1'b1, 2'b10, 16'h0001, 16'h4000);
    step(1'b1, 2'b10, 16'h0001, 16'h3FFF);
    step(1'b1, 2'b10, 16'h8000, 16'h8000);
    step(1'b1, 2'b10, 16'h4000, 16'h4000, 1'b0, 1'b0, 1'b1);
    step(1'b1, 2'b10, 16'h7FFF, 16'h7FFF, 1'b0, 1'b0, 1'b1);
    step(1'b1, 2'b10, 16'hFFFF, 16'h4000);
    // R11 ignored flags on multiply and add/sub
    step(1'b1, 2'b10, 16'h5555, 16'h3333, 1'b1, 1'b1, 1'b0, 4'd9, "R11");
    step(1'b1, 2'b00, 16'h1000, 16'h0100, 1'b0, 1'b0, 1'b0, 4'd15, "R11");
    step(1'b1, 2'b01, 16'h1000, 16'h0100, 1'b0, 1'b0, 1'b0, 4'd7, "R11");
    // R10 every shift distance on a negative and a positive source
    for (int k = 0; k < W; k++)
      step(1'b1, 2'b11, 16'h8000, 16'hFFFF, 1'b1, 1'b1, 1'b1, SW'(k));
    for (int k = 0; k < W; k++)
      step(1'b1, 2'b11, 16'h6ACF, 16'h0000, 1'b0, 1'b1, 1'b0, SW'(k));
    // Mixed random run
    for (int n = 0; n < 4000; n++)
      step($urandom_range(3, 0) != 0, 2'($urandom), pick(), pick(),
           1'($urandom), 1'($urandom), 1'($urandom), SW'($urandom));
    step(1'b0);
    step(1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule